// File: doc/BRIEF.md
# DRAM Refresh and Page-Mode Controller

This block sits between a simple processor-side request port and an asynchronous DRAM array whose row and column addresses share one multiplexed address bus. Each accepted request address is split into a row and a column. The controller opens the row by driving it on the bus and pulling the active-low row strobe low. After a set delay it drives the column on the bus and pulses the active-low column strobe. Reads return the addressed cell's data once the column strobe has completed. While a row stays open, further requests to that same row are served by column strobes alone (page mode). A request to another row closes the page, waits out the precharge time and opens the new row.

An interval timer runs continuously and raises one refresh request per row interval. The interval is the total refresh period in milliseconds times the clocks per millisecond, divided by the number of rows. Requests are held in a counter. Whenever the controller is free, it performs a row-strobe-only refresh of the row named by an internal row counter. The row counter then advances and wraps after the last row. A refresh never interrupts an access in progress. A pending refresh closes an open page and blocks new requests until it has been served.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is asserted, the row, column and write strobes are high (inactive) and `rd_valid` is low.
- R2: The upper ROW_W bits of `req_addr` select the row and the lower COL_W bits select the column. The row is on `dram_addr` when the row strobe falls, and the column is on `dram_addr` when the column strobe falls. The column strobe is low only while the row strobe is low.
- R3: The first column strobe of a row-open period falls exactly T_RCD clocks after the row strobe falls.
- R4: Each column strobe stays low for exactly T_CAS clocks. On a write, `dram_we_n` is low and `dram_dq_out` carries the request data during that strobe. On a read, `dram_we_n` stays high.
- R5: A read raises `rd_valid` for one clock, in the first clock after its column strobe rises, with the data of the addressed cell. No other clock has `rd_valid` high.
- R6: With the row open and no refresh pending, a request to the same row is accepted without releasing the row strobe. Consecutive same-row requests share one row-open period.
- R7: A request to a different row releases the row strobe and opens the new row. Every column access belongs to the row latched at the last row-strobe fall.
- R8: The row strobe stays high for at least T_RP clocks (T_RP >= 2) between any two low periods.
- R9: With no traffic, refreshes start exactly INTERVAL = REF_MS*CLK_PER_MS/2^ROW_W clocks apart.
- R10: A refresh holds the row strobe low for T_RCD+T_CAS clocks with the column strobe high and the refresh row on the bus. The refresh row starts at 0, advances by one per refresh and wraps after row 2^ROW_W-1.
- R11: No refresh starts while an accepted request has not yet had its column strobe.
- R12: Refresh requests are counted, not flagged. The number of refreshes done trails the number of elapsed intervals by at most two.
- R13: `req_ready` is low whenever the column strobe is low. A request is accepted in a clock in which `req_valid` and `req_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Request address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Read data |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | DATA_W | Data to the array |
| dram_dq_in | input | DATA_W | Data from the array |

## Verification
A request that is accepted while the row is closed shows its column strobe T_RCD clocks after the row strobe falls. A request accepted from an open page shows its column strobe in the very next clock. Read data follows in the clock after the column strobe rises. A refresh closes T_RCD+T_CAS clocks after its row strobe falls. The bench samples every output two nanoseconds after each falling clock edge, after the state has settled from the rising edge. A behavioural model of the array and of the expected access order is updated on every such sample. Each strobe edge is checked against those cycle counts in the clock where it occurs.

// File: rtl/dram_pc_pkg.sv
package dram_pc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // row strobe high, precharge counting
    ST_RCD,    // row open, waiting row-to-column delay
    ST_CAS,    // column strobe low
    ST_OPEN,   // row open, column strobe high
    ST_REF     // row-strobe-only refresh
  } seq_state_e;

endpackage

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
  parameter int ROW_W    = 4,
  parameter int INTERVAL = 12500,
  parameter int PEND_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_done,
  output logic             ref_pending,
  output logic [ROW_W-1:0] ref_row
);

  localparam int TMR_W = $clog2(INTERVAL + 1);
  localparam logic [TMR_W-1:0]  TMR_LAST = TMR_W'(INTERVAL - 1);
  localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

  logic [TMR_W-1:0]  tcnt_q, tcnt_d;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic [ROW_W-1:0]  row_q, row_d;
  logic              tick;

  always_comb begin
    tick   = (tcnt_q == TMR_LAST);
    tcnt_d = tick ? '0 : tcnt_q + 1'b1;
    pend_d = pend_q;
    if (tick && !ref_done && (pend_q != PEND_MAX)) begin
      pend_d = pend_q + 1'b1;
    end else if (!tick && ref_done) begin
      pend_d = pend_q - 1'b1;
    end
    row_d = row_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      pend_q <= '0;
      row_q  <= '0;
    end else begin
      tcnt_q <= tcnt_d;
      pend_q <= pend_d;
      if (ref_done) begin
        row_q <= row_d;
      end
    end
  end

  assign ref_pending = (pend_q != '0);
  assign ref_row     = row_q;

  // R12
  done_has_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> (pend_q != '0));

endmodule

// File: rtl/dram_access_seq.sv
module dram_access_seq
  import dram_pc_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8,
  parameter int T_RCD  = 2,
  parameter int T_CAS  = 2,
  parameter int T_RP   = 2,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_pending,
  input  logic [ROW_W-1:0]  ref_row,
  output logic              ref_done,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int T_REF    = T_RCD + T_CAS;
  localparam int CNT_TOP  = (T_REF > T_RP) ? T_REF : T_RP;
  localparam int CNT_W    = $clog2(CNT_TOP + 1);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(CNT_TOP);
  localparam logic [CNT_W-1:0] RCD_LAST = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CAS_LAST = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] REF_LAST = CNT_W'(T_REF - 1);
  localparam logic [CNT_W-1:0] RP_LAST  = CNT_W'(T_RP - 1);

  seq_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, pc_q, pc_d;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rdv_q, rdv_d;
  logic [DATA_W-1:0] rdat_q;
  logic              accept, open_row, capture, prech_ok, same_row;
  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;

  assign req_row  = req_addr[ADDR_W-1:COL_W];
  assign req_col  = req_addr[COL_W-1:0];
  assign prech_ok = (pc_q >= RP_LAST);
  assign same_row = (req_row == row_q);

  // next-state and control decode
  always_comb begin
    state_d   = state_q;
    req_ready = 1'b0;
    accept    = 1'b0;
    open_row  = 1'b0;
    capture   = 1'b0;
    ref_done  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        req_ready = prech_ok && !ref_pending;
        if (prech_ok && ref_pending) begin
          state_d = ST_REF;
        end else if (prech_ok && req_valid) begin
          accept   = 1'b1;
          open_row = 1'b1;
          state_d  = ST_RCD;
        end
      end
      ST_RCD: if (cnt_q == RCD_LAST) state_d = ST_CAS;
      ST_CAS: begin
        if (cnt_q == CAS_LAST) begin
          state_d = ST_OPEN;
          capture = !we_q;
        end
      end
      ST_OPEN: begin
        req_ready = !ref_pending && same_row;
        if (ref_pending) begin
          state_d = ST_IDLE;
        end else if (req_valid) begin
          if (same_row) begin
            accept  = 1'b1;
            state_d = ST_CAS;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_REF: begin
        if (cnt_q == REF_LAST) begin
          ref_done = 1'b1;
          state_d  = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
    rdv_d = capture;
    cnt_d = (state_d != state_q) ? '0 :
            (cnt_q == CNT_SAT) ? cnt_q : cnt_q + 1'b1;
    pc_d  = (state_q != ST_IDLE) ? '0 :
            (pc_q == CNT_SAT) ? pc_q : pc_q + 1'b1;
  end

  // state and counters
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pc_q    <= '0;
      rdv_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pc_q    <= pc_d;
      rdv_q   <= rdv_d;
    end
  end

  // request and data holding registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
      rdat_q  <= '0;
    end else begin
      if (open_row) begin
        row_q <= req_row;
      end
      if (accept) begin
        col_q   <= req_col;
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end
      if (capture) begin
        rdat_q <= dram_dq_in;
      end
    end
  end

  // array-side outputs
  always_comb begin
    dram_addr = '0;
    if (state_q == ST_CAS) begin
      dram_addr[COL_W-1:0] = col_q;
    end else if (state_q == ST_REF) begin
      dram_addr[ROW_W-1:0] = ref_row;
    end else begin
      dram_addr[ROW_W-1:0] = row_q;
    end
  end

  assign dram_ras_n  = (state_q == ST_IDLE);
  assign dram_cas_n  = (state_q != ST_CAS);
  assign dram_we_n   = !((state_q == ST_CAS) && we_q);
  assign dram_dq_out = wdata_q;
  assign rd_valid    = rdv_q;
  assign rd_data     = rdat_q;

  // R8
  prech_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> $past(dram_ras_n, 2));

  // R13
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !req_ready);

  // R5
  rdv_after_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(!dram_cas_n) && dram_cas_n));

  // R4
  we_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_cas_n);

endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl #(
  parameter int ROW_W      = 4,
  parameter int COL_W      = 4,
  parameter int DATA_W     = 8,
  parameter int T_RCD      = 2,
  parameter int T_CAS      = 2,
  parameter int T_RP       = 2,
  parameter int CLK_PER_MS = 100000,
  parameter int REF_MS     = 2,
  parameter int PEND_W     = 3,
  localparam int ADDR_W = ROW_W + COL_W,
  localparam int MUX_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [MUX_W-1:0]  dram_addr,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [DATA_W-1:0] dram_dq_out,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int ROWS     = 1 << ROW_W;
  localparam int INTERVAL = (REF_MS * CLK_PER_MS) / ROWS;

  logic [1:0]       rst_pipe;
  logic             rst_int_n;
  logic             ref_pending, ref_done;
  logic [ROW_W-1:0] ref_row;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_int_n = rst_pipe[1];

  dram_refresh_sched #(
    .ROW_W    (ROW_W),
    .INTERVAL (INTERVAL),
    .PEND_W   (PEND_W)
  ) u_sched (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .ref_done    (ref_done),
    .ref_pending (ref_pending),
    .ref_row     (ref_row)
  );

  dram_access_seq #(
    .ROW_W  (ROW_W),
    .COL_W  (COL_W),
    .DATA_W (DATA_W),
    .T_RCD  (T_RCD),
    .T_CAS  (T_CAS),
    .T_RP   (T_RP)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .ref_pending (ref_pending),
    .ref_row     (ref_row),
    .ref_done    (ref_done),
    .dram_addr   (dram_addr),
    .dram_ras_n  (dram_ras_n),
    .dram_cas_n  (dram_cas_n),
    .dram_we_n   (dram_we_n),
    .dram_dq_out (dram_dq_out),
    .dram_dq_in  (dram_dq_in)
  );

  // R10
  ref_addr_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ref_done |-> (dram_cas_n && !dram_ras_n && (dram_addr[ROW_W-1:0] == ref_row)));

endmodule

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;

  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RCD = 2, T_CAS = 2, T_RP = 2;
  localparam int CLK_PER_MS = 400, REF_MS = 2;
  localparam int ROWS = 1 << ROW_W;
  localparam int INTERVAL = (REF_MS * CLK_PER_MS) / ROWS;
  localparam int ADDR_W = ROW_W + COL_W;
  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid;
  logic [DATA_W-1:0] rd_data, dq_out, dq_in;
  logic [MUX_W-1:0] dram_addr;
  logic ras_n, cas_n, we_n;

  always #5 clk = ~clk;

  dram_page_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RP(T_RP), .CLK_PER_MS(CLK_PER_MS), .REF_MS(REF_MS), .PEND_W(3)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .dram_addr(dram_addr),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n),
    .dram_dq_out(dq_out), .dram_dq_in(dq_in)
  );

  int checks = 0, errors = 0;
  bit done_flag = 0;

  // behavioural array and expectations
  logic [DATA_W-1:0] dmem [0:(1<<ADDR_W)-1];
  int ref_mem [0:(1<<ADDR_W)-1];
  logic [ROW_W-1:0] m_row = '0;
  int acc_addr[$], acc_we[$], acc_dat[$], exp_rd[$];

  assign dq_in = dmem[{m_row, dram_addr[COL_W-1:0]}];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor state
  int cyc = 0, ras_high_cnt = T_RP, ras_low_cnt = 0, cas_low_cnt = 0;
  int cas_in_period = 0, fall_cyc = 0, last_period_cas = 0;
  int refreshes = 0, exp_ref_row = 0;
  bit prev_ras = 1'b1, prev_cas = 1'b1, cur_rd = 1'b0;

  always @(negedge clk) begin
    #2;
    if (rst_n && !done_flag) begin
      cyc++;
      if (ras_n && !prev_ras) begin
        if (cas_in_period == 0) begin
          chk(ras_low_cnt == T_RCD + T_CAS, "R10 refresh row-strobe width", ras_low_cnt, T_RCD + T_CAS);
          chk(int'(m_row) == exp_ref_row, "R10 refresh row", int'(m_row), exp_ref_row);
          chk(acc_addr.size() == 0, "R11 refresh with access outstanding", acc_addr.size(), 0);
          exp_ref_row = (exp_ref_row + 1) % ROWS;
          refreshes++;
        end else begin
          last_period_cas = cas_in_period;
        end
        ras_high_cnt = 0;
      end
      if (!ras_n && prev_ras) begin
        chk(ras_high_cnt >= T_RP, "R8 precharge", ras_high_cnt, T_RP);
        m_row = dram_addr[ROW_W-1:0];
        ras_low_cnt = 0;
        cas_in_period = 0;
        fall_cyc = cyc;
      end
      if (ras_n) ras_high_cnt++; else ras_low_cnt++;
      if (!cas_n && prev_cas) begin
        chk(!ras_n, "R2 column strobe under row strobe", int'(ras_n), 0);
        if (cas_in_period == 0)
          chk(cyc - fall_cyc == T_RCD, "R3 row-to-column delay", cyc - fall_cyc, T_RCD);
        cas_in_period++;
        if (acc_addr.size() == 0) begin
          chk(1'b0, "R7 column strobe without request", 1, 0);
        end else begin
          int a, w, d;
          a = acc_addr.pop_front();
          w = acc_we.pop_front();
          d = acc_dat.pop_front();
          chk(int'({m_row, dram_addr[COL_W-1:0]}) == a, "R7 accessed address",
              int'({m_row, dram_addr[COL_W-1:0]}), a);
          chk(int'(we_n) == (w == 0 ? 1 : 0), "R4 write enable", int'(we_n), (w == 0 ? 1 : 0));
          if (w != 0) chk(int'(dq_out) == d, "R4 write data", int'(dq_out), d);
          cur_rd = (w == 0);
        end
        cas_low_cnt = 0;
      end
      if (!cas_n) begin
        cas_low_cnt++;
        chk(!req_ready, "R13 ready low during column strobe", int'(req_ready), 0);
        if (!we_n) dmem[{m_row, dram_addr[COL_W-1:0]}] = dq_out;
      end
      if (cas_n && !prev_cas) begin
        chk(cas_low_cnt == T_CAS, "R4 column strobe width", cas_low_cnt, T_CAS);
        if (cur_rd) begin
          chk(rd_valid, "R5 read valid", int'(rd_valid), 1);
          if (exp_rd.size() > 0) begin
            int e;
            e = exp_rd.pop_front();
            chk(int'(rd_data) == e, "R5 read data", int'(rd_data), e);
          end
        end else begin
          chk(!rd_valid, "R5 no valid after write", int'(rd_valid), 0);
        end
      end else if (rd_valid) begin
        chk(1'b0, "R5 stray read valid", 1, 0);
      end
      prev_ras = ras_n;
      prev_cas = cas_n;
    end
  end

  task automatic issue(input bit we, input int a, input int d);
    bit got;
    got = 1'b0;
    req_valid = 1'b1;
    req_we = we;
    req_addr = ADDR_W'(a);
    req_wdata = DATA_W'(d);
    while (!got) begin
      #1;
      if (req_ready) begin
        got = 1'b1;
        acc_addr.push_back(a);
        acc_we.push_back(int'(we));
        acc_dat.push_back(d);
        if (we) ref_mem[a] = d;
        else exp_rd.push_back(ref_mem[a]);
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
  endtask

  task automatic wait_refresh();
    int r0;
    r0 = refreshes;
    while (refreshes == r0) @(negedge clk);
  endtask

  task automatic finish_run();
    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(10 * 150000);
    if (!done_flag) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual 0 expected 1");
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < (1 << ADDR_W); i++) begin
      dmem[i] = '0;
      ref_mem[i] = 0;
    end
    repeat (5) @(negedge clk);
    // R1 reset state
    chk(ras_n, "R1 row strobe in reset", int'(ras_n), 1);
    chk(cas_n, "R1 column strobe in reset", int'(cas_n), 1);
    chk(we_n, "R1 write enable in reset", int'(we_n), 1);
    chk(!rd_valid, "R1 read valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // scattered writes then reads across rows (R2, R4, R5, R7)
    for (int i = 0; i < 48; i++) issue(1'b1, (i * 37 + 11) & 8'hff, (i * 29 + 3) & 8'hff);
    for (int i = 47; i >= 0; i--) issue(1'b0, (i * 37 + 11) & 8'hff, 0);

    // R6 page burst of four reads in row 5, then a different row closes it
    wait_refresh();
    for (int c = 0; c < 4; c++) issue(1'b0, (5 << COL_W) | c, 0);
    issue(1'b0, (9 << COL_W) | 1, 0);
    chk(last_period_cas == 4, "R6 page burst in one row-open period", last_period_cas, 4);

    // write then read back within one row, alternating
    for (int j = 0; j < 16; j++) begin
      issue(1'b1, (3 << COL_W) | j, 8'hA0 ^ j);
      issue(1'b0, (3 << COL_W) | j, 0);
    end

    // R10 row counter wraps: run past one full pass of rows
    while (refreshes < ROWS + 2) @(negedge clk);

    // R9 idle spacing of refreshes
    begin
      int c0;
      wait_refresh();
      c0 = cyc;
      wait_refresh();
      chk(cyc - c0 == INTERVAL, "R9 refresh spacing", cyc - c0, INTERVAL);
    end

    repeat (30) @(negedge clk);
    #3;
    chk(exp_rd.size() == 0, "R5 all reads returned", exp_rd.size(), 0);
    chk(acc_addr.size() == 0, "R7 all requests performed", acc_addr.size(), 0);
    begin
      int ticks;
      ticks = cyc / INTERVAL;
      chk(refreshes <= ticks && refreshes >= ticks - 2, "R12 refresh count", refreshes, ticks);
    end
    finish_run();
  end

endmodule